// File: doc/BRIEF.md
# Gather Cache-Line Coalescing Detector

This block sits beside a vector gather unit. It receives one scalar base address, a vector of element indices, an active-element mask and an element size. From these it works out which active elements land on the same 64-byte cache line, so that the load issue logic fetches each distinct line only once. For every element it reports a group id, a leader flag and a byte offset within the line. It also reports a count of the distinct line fetches that are needed.

Line identity is found without subtracting full addresses. Each lane adds the low six bits of the base to the low bits of the scaled index, and the carry out of that add moves the line number up by one. Lanes are then matched by equality of their line numbers. An element that straddles a line boundary by itself is kept apart from every group. The result is registered, so the answer for a request accepted on one edge is on the outputs after that edge. A new request can be accepted on every cycle.

Top module: `gather_line_coalescer`

## Requirements
- R1: The effective address of element i is `in_base` plus its unsigned index times the element size, taken modulo 2^ADDR_W. The element size is 4 bytes when `in_elem8`=0 and 8 bytes when `in_elem8`=1. Index i is `in_index[i*IDX_W +: IDX_W]`.
- R2: For an active element, `out_offset[i*6 +: 6]` equals the low six bits of its effective address.
- R3: An active element that is not split reports as its group id (`out_group[i*GID_W +: GID_W]`) the number of the lowest-numbered active, non-split element whose effective address has the same bits above bit 5, itself included.
- R4: `out_leader[i]` is set for the lowest-numbered active, non-split element on each line and for every active split element. It is clear for all other elements.
- R5: An active element is split (`out_split[i]`=1) when its offset plus its element size exceeds 64. A split element reports its own number as its group id, and it never joins or absorbs another element.
- R6: An element whose `in_mask` bit is 0 reports leader 0, split 0, group id 0 and offset 0.
- R7: `out_line_count` equals the number of leader flags set.
- R8: A request is accepted when `in_valid` and `in_ready` are both high at a rising edge. `out_valid` is high for exactly the cycle after each acceptance, so back-to-back requests give back-to-back results. All result outputs hold their values when no request is accepted.
- R9: While `rst_n` is low, `out_valid` and `in_ready` are 0. `in_ready` becomes 1 at the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_base | input | ADDR_W | Scalar base address |
| in_index | input | N_ELEM*IDX_W | Packed unsigned element indices |
| in_mask | input | N_ELEM | Active-element mask |
| in_elem8 | input | 1 | 1 selects 8-byte elements, 0 selects 4-byte elements |
| out_valid | output | 1 | Result valid |
| out_leader | output | N_ELEM | One flag per distinct line fetch |
| out_split | output | N_ELEM | Element straddles a line boundary |
| out_group | output | N_ELEM*GID_W | Packed group ids |
| out_offset | output | N_ELEM*6 | Packed byte offsets within the line |
| out_line_count | output | CNT_W | Number of distinct line fetches |

## Verification
A wrong carry or line number in one lane shows up as a wrong group id or leader flag. It also shows as a count that is off by one, and all of this appears in the single result cycle after the request. A broken priority among matching lanes appears at the ports as a group id that points to a higher-numbered element. A faulty output register shows up either as `out_valid` in the wrong cycle or as results that change while no request is accepted. The strides, the unaligned bases, the address wrap, the large indices and the masks in the tests are chosen to bring out each of these faults in the first cycle after acceptance.

// File: rtl/gcl_pkg.sv
package gcl_pkg;

   typedef enum logic {
      ESIZE_WORD  = 1'b0,
      ESIZE_DWORD = 1'b1
   } esize_e;

   function automatic int unsigned esize_bytes(esize_e sz);
      return (sz == ESIZE_DWORD) ? 32'd8 : 32'd4;
   endfunction

   function automatic int unsigned esize_shift(esize_e sz);
      return (sz == ESIZE_DWORD) ? 32'd3 : 32'd2;
   endfunction

endpackage

// File: rtl/gcl_lane.sv
module gcl_lane
   import gcl_pkg::*;
#(
   parameter int ADDR_W     = 48,
   parameter int IDX_W      = 32,
   parameter int LINE_BYTES = 64,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = ADDR_W - OFF_W
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  index,
   input  esize_e            esize,
   input  logic              active,
   output logic [LINE_W-1:0] line,
   output logic [OFF_W-1:0]  offset,
   output logic              split
);
   localparam int SIDX_W = IDX_W + 3;
   localparam int SHI_W  = SIDX_W - OFF_W;

   logic [SIDX_W-1:0] scaled;
   logic [OFF_W:0]    low_sum;
   logic [LINE_W-1:0] idx_hi;
   logic [OFF_W:0]    tail;
   logic [OFF_W:0]    esz;

   always_comb begin
      scaled = SIDX_W'({3'b000, index} << esize_shift(esize));
   end

   assign low_sum = {1'b0, base[OFF_W-1:0]} + {1'b0, scaled[OFF_W-1:0]};

   generate
      if (SIDX_W < ADDR_W) begin : g_idx_extend
         assign idx_hi = {{(LINE_W-SHI_W){1'b0}}, scaled[SIDX_W-1:OFF_W]};
      end else begin : g_idx_exact
         assign idx_hi = scaled[SIDX_W-1:OFF_W];
      end
   endgenerate

   // Line number: upper base bits plus upper index bits plus the low-sum carry.
   assign line = base[ADDR_W-1:OFF_W] + idx_hi + LINE_W'(low_sum[OFF_W]);

   assign esz    = (OFF_W+1)'(esize_bytes(esize));
   assign tail   = {1'b0, low_sum[OFF_W-1:0]} + esz;
   assign split  = active && (tail > (OFF_W+1)'(LINE_BYTES));
   assign offset = active ? low_sum[OFF_W-1:0] : '0;

endmodule

// File: rtl/gcl_group.sv
module gcl_group #(
   parameter int N_ELEM = 8,
   parameter int LINE_W = 42,
   localparam int GID_W = $clog2(N_ELEM)
) (
   input  logic [N_ELEM-1:0][LINE_W-1:0] line,
   input  logic [N_ELEM-1:0]             active,
   input  logic [N_ELEM-1:0]             split,
   output logic [N_ELEM-1:0]             leader,
   output logic [N_ELEM-1:0][GID_W-1:0]  gid
);
   logic [N_ELEM-1:0] mergeable;

   assign mergeable = active & ~split;

   generate
      for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
         logic [GID_W-1:0] gid_c;
         logic             lead_c;
         logic             hit;

         always_comb begin
            gid_c  = GID_W'(i);
            lead_c = 1'b0;
            hit    = 1'b0;
            if (!active[i]) begin
               gid_c = '0;
            end else if (split[i]) begin
               lead_c = 1'b1;
            end else begin
               for (int j = 0; j < i; j++) begin
                  if (!hit && mergeable[j] && (line[j] == line[i])) begin
                     hit   = 1'b1;
                     gid_c = GID_W'(j);
                  end
               end
               lead_c = !hit;
            end
         end

         assign gid[i]    = gid_c;
         assign leader[i] = lead_c;
      end
   endgenerate

endmodule

// File: rtl/gcl_popcount.sv
module gcl_popcount #(
   parameter int N_ELEM = 8,
   localparam int CNT_W = $clog2(N_ELEM + 1)
) (
   input  logic [N_ELEM-1:0] bits,
   output logic [CNT_W-1:0]  count
);
   always_comb begin
      count = '0;
      for (int k = 0; k < N_ELEM; k++) begin
         count = count + CNT_W'(bits[k]);
      end
   end
endmodule

// File: rtl/gather_line_coalescer.sv
module gather_line_coalescer
   import gcl_pkg::*;
#(
   parameter int N_ELEM     = 8,
   parameter int ADDR_W     = 48,
   parameter int IDX_W      = 32,
   parameter int LINE_BYTES = 64,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int GID_W     = $clog2(N_ELEM),
   localparam int CNT_W     = $clog2(N_ELEM + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [ADDR_W-1:0]         in_base,
   input  logic [N_ELEM*IDX_W-1:0]   in_index,
   input  logic [N_ELEM-1:0]         in_mask,
   input  logic                      in_elem8,
   output logic                      out_valid,
   output logic [N_ELEM-1:0]         out_leader,
   output logic [N_ELEM-1:0]         out_split,
   output logic [N_ELEM*GID_W-1:0]   out_group,
   output logic [N_ELEM*OFF_W-1:0]   out_offset,
   output logic [CNT_W-1:0]          out_line_count
);
   localparam int LINE_W = ADDR_W - OFF_W;

   initial begin
      assert (N_ELEM >= 2 && N_ELEM <= 16)
         else $error("N_ELEM must lie in 2..16");
      assert (LINE_BYTES >= 8 && (1 << OFF_W) == LINE_BYTES)
         else $error("LINE_BYTES must be a power of two of at least 8");
      assert (IDX_W + 3 <= ADDR_W && IDX_W + 3 > OFF_W)
         else $error("IDX_W must satisfy OFF_W < IDX_W+3 <= ADDR_W");
   end

   esize_e                           esize;
   logic [N_ELEM-1:0][LINE_W-1:0]    lane_line;
   logic [N_ELEM-1:0][OFF_W-1:0]     lane_off;
   logic [N_ELEM-1:0]                lane_split;
   logic [N_ELEM-1:0]                grp_leader;
   logic [N_ELEM-1:0][GID_W-1:0]     grp_gid;
   logic [CNT_W-1:0]                 lead_count;
   logic                             accept;

   assign esize  = esize_e'(in_elem8);
   assign accept = in_valid && in_ready;

   generate
      for (genvar i = 0; i < N_ELEM; i++) begin : g_lane
         gcl_lane #(
            .ADDR_W     (ADDR_W),
            .IDX_W      (IDX_W),
            .LINE_BYTES (LINE_BYTES)
         ) u_lane (
            .base   (in_base),
            .index  (in_index[i*IDX_W +: IDX_W]),
            .esize  (esize),
            .active (in_mask[i]),
            .line   (lane_line[i]),
            .offset (lane_off[i]),
            .split  (lane_split[i])
         );
      end
   endgenerate

   gcl_group #(
      .N_ELEM (N_ELEM),
      .LINE_W (LINE_W)
   ) u_group (
      .line   (lane_line),
      .active (in_mask),
      .split  (lane_split),
      .leader (grp_leader),
      .gid    (grp_gid)
   );

   gcl_popcount #(
      .N_ELEM (N_ELEM)
   ) u_count (
      .bits  (grp_leader),
      .count (lead_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_ready       <= 1'b0;
         out_valid      <= 1'b0;
         out_leader     <= '0;
         out_split      <= '0;
         out_group      <= '0;
         out_offset     <= '0;
         out_line_count <= '0;
      end else begin
         in_ready  <= 1'b1;
         out_valid <= accept;
         if (accept) begin
            out_leader     <= grp_leader;
            out_split      <= lane_split;
            out_group      <= grp_gid;
            out_offset     <= lane_off;
            out_line_count <= lead_count;
         end
      end
   end

   // Result appears exactly one cycle after acceptance (R8).
   assert_result_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid);
   assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> !out_valid);
   assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> ($stable(out_leader) && $stable(out_group) && $stable(out_offset)));
   // Masked-off elements never lead or split (R6).
   assert_inactive_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (((out_leader | out_split) & ~$past(in_mask)) == '0));
   // A split element always leads its own fetch (R5).
   assert_split_leads_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_split & ~out_leader) == '0));
   // The lowest active element always leads (R4).
   assert_first_active_leads_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_mask[0]) |=> out_leader[0]);
   // Count agrees with the registered leader flags (R7).
   assert_count_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(out_leader) == int'(out_line_count)));

endmodule

// File: tb/gather_line_coalescer_bench.sv
module gather_line_coalescer_bench;
   localparam int N   = 8;
   localparam int AW  = 48;
   localparam int IW  = 32;
   localparam int OW  = 6;
   localparam int GW  = 3;
   localparam int CW  = 4;

   typedef struct packed {
      logic [AW-1:0] base;
      logic [IW-1:0] start;
      logic [IW-1:0] stride;
      logic [N-1:0]  mask;
      logic          e8;
      logic [CW-1:0] lines;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{48'h0000_0000_1000, 32'd0, 32'd1,         8'hFF, 1'b0, 4'd1},
      '{48'h0000_0000_1000, 32'd0, 32'd16,        8'hFF, 1'b0, 4'd8},
      '{48'h0000_0000_103C, 32'd0, 32'd1,         8'hFF, 1'b0, 4'd2},
      '{48'h0000_0000_1002, 32'd0, 32'd1,         8'hFF, 1'b1, 4'd2},
      '{48'h0000_0000_2000, 32'd0, 32'd2,         8'h5A, 1'b1, 4'd2},
      '{48'h0000_0000_2000, 32'd0, 32'd1,         8'h00, 1'b1, 4'd0},
      '{48'h0000_0000_2000, 32'd5, 32'd0,         8'hFF, 1'b1, 4'd1},
      '{48'hFFFF_FFFF_FFC0, 32'd0, 32'd4,         8'hFF, 1'b0, 4'd2},
      '{48'h0000_0000_1000, 32'd0, 32'hFFFF_FFFF, 8'hFF, 1'b0, 4'd2},
      '{48'h0000_0000_103E, 32'd0, 32'd0,         8'h03, 1'b0, 4'd2}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [AW-1:0]     in_base = '0;
   logic [N*IW-1:0]   in_index = '0;
   logic [N-1:0]      in_mask = '0;
   logic              in_elem8 = 1'b0;
   logic              out_valid;
   logic [N-1:0]      out_leader;
   logic [N-1:0]      out_split;
   logic [N*GW-1:0]   out_group;
   logic [N*OW-1:0]   out_offset;
   logic [CW-1:0]     out_line_count;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [N-1:0]    exp_leader;
   logic [N-1:0]    exp_split;
   logic [N*GW-1:0] exp_group;
   logic [N*OW-1:0] exp_offset;
   logic [CW-1:0]   exp_count;

   always #2.5 clk = ~clk;

   gather_line_coalescer u_gather_line_coalescer (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (in_valid),
      .in_ready       (in_ready),
      .in_base        (in_base),
      .in_index       (in_index),
      .in_mask        (in_mask),
      .in_elem8       (in_elem8),
      .out_valid      (out_valid),
      .out_leader     (out_leader),
      .out_split      (out_split),
      .out_group      (out_group),
      .out_offset     (out_offset),
      .out_line_count (out_line_count)
   );

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Reference model written from the requirements using full-width addresses.
   task automatic model(input logic [AW-1:0] base, input logic [N*IW-1:0] idx,
                        input logic [N-1:0] mask, input logic e8);
      logic [AW-1:0]   ea   [N];
      logic [AW-7:0]   ln   [N];
      logic [N-1:0]    sp;
      int              esz;
      esz = e8 ? 8 : 4;
      sp  = '0;
      exp_offset = '0;
      for (int i = 0; i < N; i++) begin
         ea[i] = base + (AW'(idx[i*IW +: IW]) * AW'(esz));
         ln[i] = ea[i][AW-1:6];
         if (mask[i]) begin
            exp_offset[i*OW +: OW] = ea[i][5:0];
            sp[i] = (int'(ea[i][5:0]) + esz) > 64;
         end
      end
      exp_split  = sp;
      exp_leader = '0;
      exp_group  = '0;
      for (int i = 0; i < N; i++) begin
         if (mask[i]) begin
            exp_group[i*GW +: GW] = GW'(i);
            exp_leader[i] = 1'b1;
            if (!sp[i]) begin
               for (int j = i - 1; j >= 0; j--) begin
                  if (mask[j] && !sp[j] && ln[j] == ln[i]) begin
                     exp_group[i*GW +: GW] = GW'(j);
                     exp_leader[i] = 1'b0;
                  end
               end
            end
         end
      end
      exp_count = CW'($countones(exp_leader));
   endtask

   task automatic check_result(string tag);
      check("R8", {tag, " out_valid"}, 64'(out_valid), 64'd1);
      check("R4", {tag, " leader"},    64'(out_leader), 64'(exp_leader));
      check("R5", {tag, " split"},     64'(out_split),  64'(exp_split));
      check("R3", {tag, " group"},     64'(out_group),  64'(exp_group));
      check("R2", {tag, " offset"},    64'(out_offset), 64'(exp_offset));
      check("R7", {tag, " count"},     64'(out_line_count), 64'(exp_count));
   endtask

   function automatic logic [N*IW-1:0] stride_vec(logic [IW-1:0] start, logic [IW-1:0] stride);
      logic [N*IW-1:0] v;
      for (int k = 0; k < N; k++) v[k*IW +: IW] = start + IW'(k) * stride;
      return v;
   endfunction

   task automatic drive(logic [AW-1:0] b, logic [N*IW-1:0] ix, logic [N-1:0] m, logic e);
      in_valid = 1'b1;
      in_base  = b;
      in_index = ix;
      in_mask  = m;
      in_elem8 = e;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL R8 watchdog expired: actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic [N*IW-1:0] ixa;
      logic [N*IW-1:0] ixb;
      logic [N-1:0]    keep_lead;
      logic [N*GW-1:0] keep_grp;
      logic [CW-1:0]   keep_cnt;

      // R9: reset state
      repeat (3) @(negedge clk);
      check("R9", "out_valid in reset", 64'(out_valid), 64'd0);
      check("R9", "in_ready in reset",  64'(in_ready),  64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "in_ready after reset", 64'(in_ready), 64'd1);
      check("R8", "no valid when idle",   64'(out_valid), 64'd0);

      // R1..R7: table walk, one request then one idle cycle
      for (int v = 0; v < NV; v++) begin
         ixa = stride_vec(TBL[v].start, TBL[v].stride);
         drive(TBL[v].base, ixa, TBL[v].mask, TBL[v].e8);
         model(TBL[v].base, ixa, TBL[v].mask, TBL[v].e8);
         @(negedge clk);
         in_valid = 1'b0;
         check_result($sformatf("R1 vec%0d", v));
         check("R7", $sformatf("vec%0d hand count", v), 64'(out_line_count), 64'(TBL[v].lines));
         if (TBL[v].mask == '0)
            check("R6", "all-masked outputs", 64'({out_group, out_offset}), 64'd0);
         @(negedge clk);
      end

      // R3/R4: scattered duplicates, lowest number wins
      ixa = {32'd17, 32'd0, 32'd80, 32'd2, 32'd41, 32'd1, 32'd40, 32'd0};
      drive(48'h0000_0000_4000, ixa, 8'hFF, 1'b0);
      model(48'h0000_0000_4000, ixa, 8'hFF, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      check_result("R3 scattered");
      check("R3", "elem6 joins elem0", 64'(out_group[6*GW +: GW]), 64'd0);
      check("R3", "elem3 joins elem1", 64'(out_group[3*GW +: GW]), 64'd1);

      // R6: masking out the would-be leader moves leadership up
      drive(48'h0000_0000_4000, ixa, 8'hFE, 1'b0);
      model(48'h0000_0000_4000, ixa, 8'hFE, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      check_result("R6 mask lead");
      check("R6", "masked elem0 quiet",
            64'({out_leader[0], out_split[0], out_group[0 +: GW], out_offset[0 +: OW]}), 64'd0);
      check("R4", "elem2 takes lead", 64'(out_leader[2]), 64'd1);

      // R8: hold while idle
      keep_lead = out_leader;
      keep_grp  = out_group;
      keep_cnt  = out_line_count;
      repeat (3) @(negedge clk);
      check("R8", "idle out_valid", 64'(out_valid), 64'd0);
      check("R8", "hold leader", 64'(out_leader), 64'(keep_lead));
      check("R8", "hold group",  64'(out_group),  64'(keep_grp));
      check("R8", "hold count",  64'(out_line_count), 64'(keep_cnt));

      // R8: back-to-back requests
      ixa = stride_vec(32'd0, 32'd16);
      ixb = stride_vec(32'd3, 32'd1);
      drive(48'h0000_0000_8000, ixa, 8'hFF, 1'b0);
      @(negedge clk);
      model(48'h0000_0000_8000, ixa, 8'hFF, 1'b0);
      check_result("R8 b2b first");
      drive(48'h0000_0000_8030, ixb, 8'hFF, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      model(48'h0000_0000_8030, ixb, 8'hFF, 1'b1);
      check_result("R8 b2b second");
      @(negedge clk);
      check("R8", "valid drops after burst", 64'(out_valid), 64'd0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule